// File: doc/BRIEF.md
# Packed SIMD Shift Unit

This block shifts a 64-bit operand as a set of independent lanes: four 16-bit words, two 32-bit doublewords or one 64-bit quadword. It performs logical left, logical right and arithmetic right shifts. The shift amount comes either from a second 64-bit operand, which may be a register or a memory value fetched by surrounding logic, or from an 8-bit immediate. The operation and the lane size are chosen by decoding a two-byte opcode. For the immediate forms, the mod and reg fields of the ModRM byte also take part in the decode.

Operations enter on a valid/ready input stream. Each accepted operation produces one registered result on a valid/ready output stream in the next cycle. The result carries a flag that marks an unsupported encoding. An operation moves in on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, which means `in_ready = !out_valid || out_ready`. While a result is waiting and `out_ready` is low, the result and its flag hold steady and no new operation is taken. The upstream side must then keep its operation presented.

Top module: `simd_shift_unit`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: An operation accepted on one rising edge appears on `out_data`/`out_illegal` with `out_valid` high right after the next rising edge. This gives one result per cycle when `out_ready` stays high.
- R3: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_data`, `out_illegal` and `out_valid` hold their values. When `out_ready` rises, a waiting input is taken on that same edge.
- R4: With `op_esc` = 0x0F, the count-operand forms are selected by `op_code`: 0xF1 word left logical, 0xD1 word right logical, 0xE1 word right arithmetic, 0xD2 doubleword right logical, 0xE2 doubleword right arithmetic, 0xD3 quadword right logical. The count is `src_b`, and `modrm_hi` is not decoded for these forms.
- R5: With `op_esc` = 0x0F, the immediate forms are selected by `op_code`: 0x71 for words, 0x72 for doublewords, 0x73 for the quadword. The reg field `modrm_hi[2:0]` picks the shift: 3'b110 is left logical, 3'b010 is right logical and 3'b100 is right arithmetic. The count is `imm` zero-extended.
- R6: Logical shifts fill the vacated bits of each lane with zeros.
- R7: Arithmetic right shifts fill the vacated bits of each lane with that lane's sign bit.
- R8: The count is treated as an unsigned number of full width. A count at or above the lane width gives an all-zero lane for logical shifts and an all-sign lane for arithmetic shifts. Bits above bit 7 of `src_b` count toward this.
- R9: An encoding is illegal in any of these cases: `op_esc` is not 0x0F; `op_code` is none of the nine bytes above; an immediate form has a reg field outside {110, 010, 100}; 0x73 is paired with reg 100; or an immediate form has mod (`modrm_hi[4:3]`) other than 2'b11. An illegal encoding sets `out_illegal` and returns `src_a` unchanged. Legal encodings give `out_illegal` = 0.
- R10: No bit crosses a lane boundary. Each lane's result depends only on that lane of `src_a` and on the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An operation is presented |
| in_ready | output | 1 | The unit accepts the presented operation |
| op_esc | input | 8 | First opcode byte, must be 0x0F |
| op_code | input | 8 | Second opcode byte |
| modrm_hi | input | 5 | ModRM mod (bits 4:3) and reg (bits 2:0) fields |
| src_a | input | 64 | Operand to shift (destination value) |
| src_b | input | 64 | Count operand for register or memory forms |
| imm | input | 8 | Immediate count |
| out_valid | output | 1 | A result is held |
| out_ready | input | 1 | Downstream takes the held result |
| out_data | output | 64 | Shifted result, or `src_a` if illegal |
| out_illegal | output | 1 | The held result came from an unsupported encoding |

## Verification
A decode fault that picks the wrong lane size or shift kind shows up in `out_data` one cycle after the faulty operation is accepted. It shows most clearly on operands whose lanes carry set sign bits near their boundaries, because bits then move between lanes or the fill changes between zeros and ones. A fault in the large-count path shows only for counts at or beyond the lane width, including counts whose only set bits are above bit 7. The bench aims operands at exactly those values. A fault in the output register shows during a stall: the held result changes, or a second operation overwrites it, and this becomes visible on the cycle the stall releases or earlier.

// File: rtl/simd_shift_pkg.sv
package simd_shift_pkg;
  localparam int CNT_W = 64;

  typedef enum logic [1:0] {
    LANE_W16 = 2'd0,
    LANE_W32 = 2'd1,
    LANE_W64 = 2'd2
  } lane_e;

  typedef enum logic [1:0] {
    SH_SLL = 2'd0,
    SH_SRL = 2'd1,
    SH_SRA = 2'd2
  } shkind_e;

  typedef struct packed {
    logic    illegal;
    logic    use_imm;
    lane_e   lane;
    shkind_e kind;
  } dec_t;
endpackage

// File: rtl/simd_shift_decode.sv
module simd_shift_decode
  import simd_shift_pkg::*;
(
  input  logic [7:0] op_esc,
  input  logic [7:0] op_code,
  input  logic [4:0] modrm_hi,
  output dec_t       dec
);
  logic       ok;
  logic [1:0] mod_f;
  logic [2:0] reg_f;

  assign mod_f = modrm_hi[4:3];
  assign reg_f = modrm_hi[2:0];

  always_comb begin
    ok          = 1'b1;
    dec.use_imm = 1'b0;
    dec.lane    = LANE_W16;
    dec.kind    = SH_SLL;
    case (op_code)
      8'hF1: begin dec.lane = LANE_W16; dec.kind = SH_SLL; end
      8'hD1: begin dec.lane = LANE_W16; dec.kind = SH_SRL; end
      8'hE1: begin dec.lane = LANE_W16; dec.kind = SH_SRA; end
      8'hD2: begin dec.lane = LANE_W32; dec.kind = SH_SRL; end
      8'hE2: begin dec.lane = LANE_W32; dec.kind = SH_SRA; end
      8'hD3: begin dec.lane = LANE_W64; dec.kind = SH_SRL; end
      8'h71, 8'h72, 8'h73: begin
        dec.use_imm = 1'b1;
        case (op_code)
          8'h71:   dec.lane = LANE_W16;
          8'h72:   dec.lane = LANE_W32;
          default: dec.lane = LANE_W64;
        endcase
        case (reg_f)
          3'b110: dec.kind = SH_SLL;
          3'b010: dec.kind = SH_SRL;
          3'b100: begin
            dec.kind = SH_SRA;
            if (op_code == 8'h73) ok = 1'b0;
          end
          default: ok = 1'b0;
        endcase
        if (mod_f != 2'b11) ok = 1'b0;
      end
      default: ok = 1'b0;
    endcase
    if (op_esc != 8'h0F) ok = 1'b0;
    dec.illegal = ~ok;
  end
endmodule

// File: rtl/simd_shift_lane.sv
module simd_shift_lane
  import simd_shift_pkg::*;
#(
  parameter int W     = 16,
  parameter int CW    = CNT_W
)(
  input  logic [W-1:0]  x,
  input  logic [CW-1:0] cnt,
  input  shkind_e       kind,
  output logic [W-1:0]  y
);
  localparam int SH_W = $clog2(W);

  logic            big;
  logic [SH_W-1:0] amt;
  logic            sgn;

  assign big = |cnt[CW-1:SH_W];
  assign amt = cnt[SH_W-1:0];
  assign sgn = x[W-1];

  always_comb begin
    case (kind)
      SH_SLL:  y = big ? '0 : (x << amt);
      SH_SRL:  y = big ? '0 : (x >> amt);
      SH_SRA:  y = big ? {W{sgn}} : W'($signed(x) >>> amt);
      default: y = x;
    endcase
  end
endmodule

// File: rtl/simd_shift_array.sv
module simd_shift_array
  import simd_shift_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LANE_W = 16
)(
  input  logic [DATA_W-1:0] a,
  input  logic [CNT_W-1:0]  cnt,
  input  shkind_e           kind,
  output logic [DATA_W-1:0] y
);
  localparam int NLANE = DATA_W / LANE_W;

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    simd_shift_lane #(.W(LANE_W), .CW(CNT_W)) u_lane (
      .x   (a[i*LANE_W +: LANE_W]),
      .cnt (cnt),
      .kind(kind),
      .y   (y[i*LANE_W +: LANE_W])
    );
  end
endmodule

// File: rtl/simd_shift_obuf.sv
module simd_shift_obuf #(
  parameter int DATA_W = 64
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] d_in,
  input  logic              ill_in,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_illegal
);
  logic load;

  assign in_ready = ~out_valid | out_ready;
  assign load     = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_illegal <= 1'b0;
    end else if (load) begin
      out_valid   <= 1'b1;
      out_data    <= d_in;
      out_illegal <= ill_in;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end

  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_illegal)));
endmodule

// File: rtl/simd_shift_unit.sv
module simd_shift_unit
  import simd_shift_pkg::*;
#(
  parameter int DATA_W = 64
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        op_esc,
  input  logic [7:0]        op_code,
  input  logic [4:0]        modrm_hi,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [7:0]        imm,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_illegal
);
  localparam int NSIZE = 3;

  dec_t              dec;
  logic [CNT_W-1:0]  count;
  logic [DATA_W-1:0] res_sz [NSIZE];
  logic [DATA_W-1:0] result;
  logic              fire;

  simd_shift_decode u_dec (
    .op_esc  (op_esc),
    .op_code (op_code),
    .modrm_hi(modrm_hi),
    .dec     (dec)
  );

  assign count = dec.use_imm ? {{(CNT_W-8){1'b0}}, imm} : CNT_W'(src_b);

  for (genvar g = 0; g < NSIZE; g++) begin : g_size
    localparam int LW = 16 << g;
    simd_shift_array #(.DATA_W(DATA_W), .LANE_W(LW)) u_arr (
      .a   (src_a),
      .cnt (count),
      .kind(dec.kind),
      .y   (res_sz[g])
    );
  end

  always_comb begin
    if (dec.illegal) result = src_a;
    else begin
      case (dec.lane)
        LANE_W16: result = res_sz[0];
        LANE_W32: result = res_sz[1];
        LANE_W64: result = res_sz[2];
        default:  result = src_a;
      endcase
    end
  end

  simd_shift_obuf #(.DATA_W(DATA_W)) u_obuf (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .d_in       (result),
    .ill_in     (dec.illegal),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .out_illegal(out_illegal)
  );

  assign fire = in_valid & in_ready;

  // R2
  one_cycle_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid);

  // R9
  illegal_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && dec.illegal) |=> (out_illegal && out_data == $past(src_a)));

  // R8
  wide_logical_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !dec.illegal && dec.kind != SH_SRA && count >= CNT_W'(64))
      |=> (out_data == '0 && !out_illegal));

  // R3
  backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

// File: tb/simd_shift_unit_bench.sv
module simd_shift_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  op_esc = 8'h0F;
  logic [7:0]  op_code = 8'h00;
  logic [4:0]  modrm_hi = 5'b11000;
  logic [63:0] src_a = '0;
  logic [63:0] src_b = '0;
  logic [7:0]  imm = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_data;
  logic        out_illegal;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_shift_unit u_simd_shift_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_esc(op_esc), .op_code(op_code), .modrm_hi(modrm_hi),
    .src_a(src_a), .src_b(src_b), .imm(imm),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_illegal(out_illegal)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // Reference: 0 = sll, 1 = srl, 2 = sra
  function automatic void ref_model(input logic [7:0] e, input logic [7:0] o,
                                    input logic [4:0] m, input logic [63:0] a,
                                    input logic [63:0] b, input logic [7:0] im,
                                    output logic [63:0] res, output logic ill);
    int lw;
    int kind;
    logic [63:0] cnt;
    logic [63:0] mask;
    ill = 1'b0; lw = 16; kind = 0; cnt = b;
    if (o == 8'hF1) begin lw = 16; kind = 0; end
    else if (o == 8'hD1) begin lw = 16; kind = 1; end
    else if (o == 8'hE1) begin lw = 16; kind = 2; end
    else if (o == 8'hD2) begin lw = 32; kind = 1; end
    else if (o == 8'hE2) begin lw = 32; kind = 2; end
    else if (o == 8'hD3) begin lw = 64; kind = 1; end
    else if (o == 8'h71 || o == 8'h72 || o == 8'h73) begin
      lw = (o == 8'h71) ? 16 : (o == 8'h72) ? 32 : 64;
      cnt = {56'd0, im};
      if (m[2:0] == 3'b110) kind = 0;
      else if (m[2:0] == 3'b010) kind = 1;
      else if (m[2:0] == 3'b100 && o != 8'h73) kind = 2;
      else ill = 1'b1;
      if (m[4:3] != 2'b11) ill = 1'b1;
    end else ill = 1'b1;
    if (e != 8'h0F) ill = 1'b1;
    if (ill) begin res = a; return; end
    res = '0;
    mask = (lw == 64) ? '1 : ((64'd1 << lw) - 64'd1);
    for (int i = 0; i < 64 / lw; i++) begin
      logic [63:0] ln, r, ext;
      logic sg;
      ln = (a >> (i * lw)) & mask;
      sg = ln[lw-1];
      if (cnt >= 64'(lw)) r = (kind == 2 && sg) ? mask : '0;
      else if (kind == 0) r = (ln << cnt) & mask;
      else if (kind == 1) r = ln >> cnt;
      else begin
        ext = sg ? (ln | ~mask) : ln;
        r = 64'($signed(ext) >>> cnt) & mask;
      end
      res = res | (r << (i * lw));
    end
  endfunction

  task automatic issue(input logic [7:0] o, input logic [4:0] m,
                       input logic [63:0] a, input logic [63:0] b, input logic [7:0] im,
                       input logic [7:0] e = 8'h0F);
    @(negedge clk);
    op_esc = e; op_code = o; modrm_hi = m; src_a = a; src_b = b; imm = im;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_op(input string req, input logic [7:0] o, input logic [4:0] m,
                        input logic [63:0] a, input logic [63:0] b, input logic [7:0] im,
                        input logic [7:0] e = 8'h0F);
    logic [63:0] er;
    logic ei;
    ref_model(e, o, m, a, b, im, er, ei);
    issue(o, m, a, b, im, e);
    check({req, " R2 valid"}, {63'd0, out_valid}, 64'd1);
    check(req, out_data, er);
    check({req, " flag"}, {63'd0, out_illegal}, {63'd0, ei});
  endtask

  task automatic t_reset;
    check("R1 out_valid", {63'd0, out_valid}, 64'd0);
    check("R1 in_ready", {63'd0, in_ready}, 64'd1);
  endtask

  task automatic t_count_forms;
    logic [63:0] a = 64'h8001_7FFE_F00F_1234;
    run_op("R4 R6 word sll", 8'hF1, 5'b11000, a, 64'd3, 8'd0);
    check("R4 word sll known", out_data, 64'h0008_FFF0_8078_91A0);
    run_op("R4 R6 word srl", 8'hD1, 5'b00101, a, 64'd4, 8'd0);
    run_op("R4 R7 word sra", 8'hE1, 5'b11000, a, 64'd5, 8'd0);
    check("R7 word sra known", out_data, 64'hFC00_03FF_FF80_0091);
    run_op("R4 dword srl", 8'hD2, 5'b11000, a, 64'd31, 8'd0);
    run_op("R4 R7 dword sra", 8'hE2, 5'b11000, a, 64'd9, 8'd0);
    run_op("R4 qword srl", 8'hD3, 5'b11000, a, 64'd63, 8'd0);
    check("R6 qword srl 63", out_data, 64'd1);
  endtask

  task automatic t_imm_forms;
    logic [63:0] a = 64'hC3A5_0F0F_8000_0001;
    run_op("R5 word imm sll", 8'h71, 5'b11110, a, 64'hFF, 8'd1);
    run_op("R5 word imm srl", 8'h71, 5'b11010, a, 64'd0, 8'd15);
    run_op("R5 word imm sra", 8'h71, 5'b11100, a, 64'd0, 8'd15);
    check("R5 R7 word imm sra known", out_data, 64'hFFFF_0000_FFFF_0000);
    run_op("R5 dword imm sll", 8'h72, 5'b11110, a, 64'd0, 8'd31);
    run_op("R5 dword imm sra", 8'h72, 5'b11100, a, 64'd0, 8'd4);
    run_op("R5 qword imm sll", 8'h73, 5'b11110, a, 64'd0, 8'd8);
    run_op("R5 qword imm srl", 8'h73, 5'b11010, a, 64'd0, 8'd63);
    run_op("R5 imm ignores src_b", 8'h71, 5'b11010, a, 64'd2, 8'd0);
    check("R5 imm count zero", out_data, a);
  endtask

  task automatic t_wide_counts;
    logic [63:0] a = 64'h8000_7FFF_8000_0001;
    run_op("R8 word sll 16", 8'hF1, 5'b11000, a, 64'd16, 8'd0);
    check("R8 word sll 16 zero", out_data, 64'd0);
    run_op("R8 word sra 16", 8'hE1, 5'b11000, a, 64'd16, 8'd0);
    check("R8 word sra sign", out_data, 64'hFFFF_0000_FFFF_0000);
    run_op("R8 high-bit count", 8'hD1, 5'b11000, a, 64'h1_0000_0001, 8'd0);
    check("R8 high-bit count zero", out_data, 64'd0);
    run_op("R8 dword sra 32", 8'hE2, 5'b11000, a, 64'd32, 8'd0);
    check("R8 dword sra 32 sign", out_data, 64'hFFFF_FFFF_FFFF_FFFF);
    run_op("R8 qword srl 64", 8'hD3, 5'b11000, a, 64'd64, 8'd0);
    run_op("R8 word imm 200", 8'h71, 5'b11100, a, 64'd0, 8'd200);
    run_op("R8 word sll 15 edge", 8'hF1, 5'b11000, a, 64'd15, 8'd0);
  endtask

  task automatic t_lanes;
    run_op("R10 word srl no cross", 8'hD1, 5'b11000, 64'hFFFF_FFFF_FFFF_FFFF, 64'd8, 8'd0);
    check("R10 word srl pattern", out_data, 64'h00FF_00FF_00FF_00FF);
    run_op("R10 dword sll no cross", 8'h72, 5'b11110, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 8'd4);
    check("R10 dword sll pattern", out_data, 64'hFFFF_FFF0_FFFF_FFF0);
  endtask

  task automatic t_illegal;
    logic [63:0] a = 64'h0123_4567_89AB_CDEF;
    run_op("R9 bad escape", 8'hD1, 5'b11000, a, 64'd1, 8'd0, 8'h0E);
    run_op("R9 qword sra imm", 8'h73, 5'b11100, a, 64'd0, 8'd1);
    check("R9 qword sra flag", {63'd0, out_illegal}, 64'd1);
    run_op("R9 bad reg field", 8'h71, 5'b11000, a, 64'd0, 8'd1);
    run_op("R9 imm mod not 11", 8'h72, 5'b01110, a, 64'd0, 8'd1);
    run_op("R9 unknown byte", 8'hF3, 5'b11000, a, 64'd1, 8'd0);
    check("R9 unknown byte data", out_data, a);
  endtask

  task automatic t_backpressure;
    logic [63:0] ea, eb;
    logic ei;
    ref_model(8'h0F, 8'hD1, 5'b11000, 64'hAAAA_5555_AAAA_5555, 64'd1, 8'd0, ea, ei);
    ref_model(8'h0F, 8'hF1, 5'b11000, 64'h1111_2222_3333_4444, 64'd2, 8'd0, eb, ei);
    @(negedge clk);
    out_ready = 1'b0;
    op_esc = 8'h0F; op_code = 8'hD1; modrm_hi = 5'b11000;
    src_a = 64'hAAAA_5555_AAAA_5555; src_b = 64'd1; in_valid = 1'b1;
    @(negedge clk);
    op_code = 8'hF1; src_a = 64'h1111_2222_3333_4444; src_b = 64'd2;
    check("R3 first held", out_data, ea);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R3 in_ready low", {63'd0, in_ready}, 64'd0);
      check("R3 data held", out_data, ea);
      check("R3 valid held", {63'd0, out_valid}, 64'd1);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R3 second taken", out_data, eb);
    check("R3 second valid", {63'd0, out_valid}, 64'd1);
    @(negedge clk);
    check("R2 drained", {63'd0, out_valid}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count_forms();
    t_imm_forms();
    t_wide_counts();
    t_lanes();
    t_illegal();
    t_backpressure();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule